// File: doc/BRIEF.md
# Host Bridge Control Register Block

This block holds the internal control and status words of a host bridge. It has 28 words of 32 bits each. A processor reaches them through a plain synchronous register port that carries a byte address, a write strobe, write data and combinational read data. The word index is the byte address shifted right by two, so the two low address bits have no effect and every access covers a whole word.

Most words are plain storage. Four words near the middle of the map work together and are not plain. A set word ORs its written value into an interrupt-enable word. A clear word removes the written bits from that same enable word. Software cannot write the enable word directly, and it cannot write the interrupt-status word either.

The general configuration word holds a self-reset bit at bit 2. Writing a 1 there while the stored bit is 0 raises a system reset request for exactly one clock. Addresses past the last word ignore writes and read back as zero.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset the words read: 0x00=0x00000C40, 0x04=0x00001384 (bits 2, 7, 8, 9 and 12 set), 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word in 0x00..0x6C reads 0, and the reset request output is 0.
- R2: A write to any word other than 0x30, 0x34, 0x38 and 0x3C stores the full 32-bit value. The new value appears on the read data in the clock cycle that follows the write edge.
- R3: A write to 0x30 stores the value at 0x30 and also ORs it into the enable word at 0x38.
- R4: A write to 0x34 stores the value at 0x34 and also clears, in the enable word at 0x38, every bit that is 1 in the written value.
- R5: Writes aimed at 0x38 (enable) or 0x3C (interrupt status) change nothing, and both words stay readable. The status word stays at 0.
- R6: A write to 0x04 whose data bit 2 is 1, while the stored bit 2 is 0, drives the reset request output high for exactly one cycle. That cycle begins at the write edge. The written value is still stored.
- R7: A write to 0x04 drives no reset request when the written bit 2 is 0 or the stored bit 2 is already 1. Writes to any other address never drive it.
- R8: A write at a byte address of 0x70 or above changes no word, and reading such an address returns 0.
- R9: Byte address bits 1:0 are ignored: an access at byte address A reaches the word with index A>>2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Random traffic covers the whole 8-bit address space with random data and unaligned low bits, which separates plain storage, the set/clear side effects, the protected words and the unmapped range. Directed writes to the configuration word try all three cases: bit 2 already set, bit 2 written as 0, and a true 0-to-1 step. This shows whether the request fires on the edge alone and whether it lasts one cycle. Paired set and clear writes with overlapping masks show whether the enable word takes an OR and an AND-NOT rather than a plain store.

// File: rtl/bcrf_pkg.sv
package bcrf_pkg;

    parameter int DATA_W    = 32;
    parameter int NUM_WORDS = 28;
    parameter int ADDR_W    = 8;
    localparam int OFF_W    = ADDR_W - 2;

    // word indexes whose behaviour is not plain storage
    localparam int CFG_IDX  = 1;
    localparam int SET_IDX  = 12;
    localparam int CLR_IDX  = 13;
    localparam int EN_IDX   = 14;
    localparam int ISR_IDX  = 15;
    localparam int RST_BIT  = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_PLAIN,
        K_CFG,
        K_SET,
        K_CLR,
        K_RO
    } wkind_e;

    typedef logic [NUM_WORDS-1:0][DATA_W-1:0] word_bank_t;

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            0:       v = 32'h0000_0C40;
            1:       v = 32'h0000_1384;
            2:       v = 32'h2BFF_8010;
            3:       v = 32'h255E_0091;
            4:       v = 32'h0000_6140;
            7:       v = 32'h0000_01FF;
            8:       v = 32'h0000_01FF;
            26:      v = 32'h0000_0008;
            27:      v = 32'h1000_0000;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bcrf_decode.sv
module bcrf_decode
    import bcrf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NW = NUM_WORDS
) (
    input  logic [AW-1:0]   addr,
    output logic [AW-3:0]   idx,
    output logic            in_range,
    output wkind_e          kind
);
    localparam int IW = AW - 2;

    logic [1:0] unused_lo;
    assign unused_lo = addr[1:0];

    always_comb begin
        idx      = addr[AW-1:2];
        in_range = (int'(idx) < NW);
        kind     = K_NONE;
        if (in_range) begin
            if (idx == IW'(CFG_IDX))
                kind = K_CFG;
            else if (idx == IW'(SET_IDX))
                kind = K_SET;
            else if (idx == IW'(CLR_IDX))
                kind = K_CLR;
            else if (idx == IW'(EN_IDX) || idx == IW'(ISR_IDX))
                kind = K_RO;
            else
                kind = K_PLAIN;
        end
    end
endmodule

// File: rtl/bcrf_store.sv
module bcrf_store
    import bcrf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = NUM_WORDS,
    parameter int IW = OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  wkind_e                   kind,
    input  logic [IW-1:0]            idx,
    input  logic [DW-1:0]            wdata,
    output logic [NW-1:0][DW-1:0]    words
);
    typedef struct packed {
        logic [NW-1:0][DW-1:0] w;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int k = 0; k < NW; k++) begin
                if (idx == IW'(k)) begin
                    unique case (kind)
                        K_PLAIN, K_CFG, K_SET, K_CLR: st_d.w[k] = wdata;
                        default: ;
                    endcase
                end
            end
            if (kind == K_SET)
                st_d.w[EN_IDX] = st_q.w[EN_IDX] | wdata;
            else if (kind == K_CLR)
                st_d.w[EN_IDX] = st_q.w[EN_IDX] & ~wdata;
        end
    end

    generate
        for (genvar g = 0; g < NW; g++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    st_q.w[g] <= reset_word(g);
                else
                    st_q.w[g] <= st_d.w[g];
            end
        end
    endgenerate

    assign words = st_q.w;

    // R3: every bit written to the set word is on in the enable word afterwards
    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_SET) |=> ((st_q.w[EN_IDX] & $past(wdata)) == $past(wdata)));

    // R4: every bit written to the clear word is off in the enable word afterwards
    assert_enable_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_CLR) |=> ((st_q.w[EN_IDX] & $past(wdata)) == '0));

    // R5: a write aimed at a protected word leaves the whole bank unchanged
    assert_protected_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_RO) |=> (st_q == $past(st_q)));

    // R8: a write outside the map leaves the whole bank unchanged
    assert_oob_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_NONE) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/bcrf_rstreq.sv
module bcrf_rstreq (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic old_bit,
    input  logic new_bit,
    output logic req
);
    typedef struct packed {
        logic req;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = cfg_wr && !old_bit && new_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req = st_q.req;

    // R6: the request never lasts longer than one cycle
    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R7: a write without a 0-to-1 step on the bit raises no request
    assert_no_false_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && new_bit && !old_bit) |=> !req);
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import bcrf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = NUM_WORDS,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr_en,
    input  logic [DW-1:0]   reg_wr_data,
    output logic [DW-1:0]   reg_rd_data,
    output logic            sys_rst_req
);
    localparam int IW = AW - 2;

    logic [IW-1:0]         idx;
    logic                  in_range;
    wkind_e                kind;
    logic [NW-1:0][DW-1:0] words;

    bcrf_decode #(.AW(AW), .NW(NW)) u_decode (
        .addr     (reg_addr),
        .idx      (idx),
        .in_range (in_range),
        .kind     (kind)
    );

    bcrf_store #(.DW(DW), .NW(NW), .IW(IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .kind  (kind),
        .idx   (idx),
        .wdata (reg_wr_data),
        .words (words)
    );

    bcrf_rstreq u_rstreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (reg_wr_en && kind == K_CFG),
        .old_bit (words[CFG_IDX][RST_BIT]),
        .new_bit (reg_wr_data[RST_BIT]),
        .req     (sys_rst_req)
    );

    always_comb begin
        reg_rd_data = '0;
        for (int k = 0; k < NW; k++) begin
            if (in_range && idx == IW'(k))
                reg_rd_data = words[k];
        end
    end

    // R8: unmapped addresses read as zero
    assert_oob_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (reg_rd_data == '0));

    // R6: a request follows only a qualifying write to the configuration word
    assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(reg_wr_en && kind == K_CFG && reg_wr_data[RST_BIT]));
endmodule

// File: tb/tb_bridge_ctl_regs.sv
module tb_bridge_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] mdl [0:27];

    always #2 clk = ~clk;

    bridge_ctl_regs dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .sys_rst_req (sys_rst_req)
    );

    function automatic logic [31:0] rst_val(input int i);
        case (i)
            0: return 32'h0000_0C40;
            1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;
            3: return 32'h255E_0091;
            4: return 32'h0000_6140;
            7, 8: return 32'h0000_01FF;
            26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int i = int'(a >> 2);
        return (i < 28) ? mdl[i] : 32'h0;
    endfunction

    // applies a write to the model; returns whether a request is due
    function automatic bit model_write(input logic [7:0] a, input logic [31:0] d);
        int i = int'(a >> 2);
        bit p = 1'b0;
        if (i >= 28) return 1'b0;
        case (i)
            1: begin p = !mdl[1][2] && d[2]; mdl[1] = d; end
            12: begin mdl[12] = d; mdl[14] = mdl[14] | d; end
            13: begin mdl[13] = d; mdl[14] = mdl[14] & ~d; end
            14, 15: ;
            default: mdl[i] = d;
        endcase
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        bit p;
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        p = model_write(a, d);
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(req, {31'b0, sys_rst_req}, {31'b0, p});
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rd_data, exp_read(a));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 28; i++) mdl[i] = rst_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values and quiet request
        check("R1 req", {31'b0, sys_rst_req}, 32'h0);
        for (int i = 0; i < 28; i++) rd(8'(i * 4), "R1");

        // R7: bit already 1, then bit written as 0
        wr(8'h04, 32'h0000_0004, "R7 already set");
        wr(8'h04, 32'h0000_1380, "R7 written 0");
        // R6: true 0-to-1 step, then one cycle wide
        wr(8'h04, 32'h0000_0004, "R6 pulse");
        @(negedge clk);
        check("R6 width", {31'b0, sys_rst_req}, 32'h0);
        rd(8'h04, "R6 stored");

        // R3 / R4 overlapping masks
        wr(8'h30, 32'hF0F0_00FF, "R3");
        rd(8'h38, "R3 enable");
        rd(8'h30, "R3 stored");
        wr(8'h34, 32'h3000_000F, "R4");
        rd(8'h38, "R4 enable");
        rd(8'h34, "R4 stored");

        // R5 protected words
        wr(8'h38, 32'hFFFF_FFFF, "R5 en write");
        rd(8'h38, "R5 en");
        wr(8'h3C, 32'hDEAD_BEEF, "R5 isr write");
        rd(8'h3C, "R5 isr");

        // R8 unmapped
        wr(8'h70, 32'h1234_5678, "R8 write");
        wr(8'hFC, 32'h8765_4321, "R8 write top");
        rd(8'h70, "R8 read");
        rd(8'hFF, "R8 read top");
        rd(8'h6C, "R8 neighbour");

        // R9 unaligned address, R2 plain storage
        wr(8'h43, 32'hCAFE_F00D, "R9 write");
        rd(8'h40, "R9 aligned");
        rd(8'h42, "R9 unaligned");
        wr(8'h14, 32'hA5A5_5A5A, "R2 write");
        rd(8'h14, "R2");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 30) * 4 + $urandom % 4);
            d = $urandom;
            if ($urandom % 2 == 1) wr(a, d, "R2 R6 R7 random write");
            else rd(a, "R2 R3 R4 R5 R8 random read");
        end
        for (int i = 0; i < 28; i++) rd(8'(i * 4), "R2 final sweep");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule